// File: doc/BRIEF.md
# Token-Threaded NEXT Accelerator

This peripheral performs the inner-interpreter step of a token-threaded Forth in hardware, so that the CPU does not have to. Software keeps a 24-bit instruction pointer inside the block. When the CPU stores any value to the trigger register, the block starts a NEXT step. It becomes a bus master and reads a 16-bit token from memory at the pointer. It then moves the pointer past the token. Finally it turns the token into a code address and writes that address into a vector register. The CPU finishes NEXT with an indirect far jump through that vector.

Only 16-bit tokens sit in memory. The wide code address is rebuilt by a selectable left shift of 0, 2, 4 or 6 bits, with zeros filled in at the bottom. All bits above the shifted token are zero, so the dictionary lives at the bottom of the address space and no base offset is added. The CPU can load the pointer bytes directly on NEST and UNNEST. If such a load arrives during a fetch, it is held back until the fetch ends. A trigger that arrives during a fetch is dropped and noted in a sticky flag.

The register window is 8 bytes of byte-wide registers:

| Offset | Register |
|---|---|
| 0 | Trigger |
| 1, 2, 3 | Pointer bytes, low to bank |
| 4, 5, 6 | Vector bytes, low to high |
| 7 | Control |

Top module: `tok_next_accel`

## Requirements
- R1: After reset, the pointer, the vector and the shift select all read zero. The block is idle: control bit 7 is 0, control bit 6 is 0 and `mem_req` is low.
- R2: A CPU write of any data value to offset 0 while the block is idle starts one NEXT step. Busy (control bit 7) reads 1 in the cycle after the write edge.
- R3: A NEXT step makes two byte reads on the memory bus.
  - The first read fetches the token's low byte from the pointer address.
  - The second read fetches the high byte from pointer+1.
  - `mem_req` and `mem_addr` stay steady until `mem_gnt` is seen, and read data is taken in the cycle of the grant.
- R4: When the step completes, the 24-bit pointer has advanced by 2. A carry out of the low 16 bits goes into the bank byte (offset 3).
- R5: The vector equals the token shifted left by 2×sel, where sel is control bits [1:0] (0→0, 1→2, 2→4, 3→6 bits). The low bits are filled with zeros and every vector bit above the shifted token is zero.
- R6: The vector changes only on the clock edge of the second grant, and busy clears on that same edge. With a grant in the first cycle of each request, busy is set for exactly two sampled cycles.
- R7: A trigger write during busy is ignored: no extra bus read takes place and the pointer moves by only 2. It sets the sticky overrun flag (control bit 6). The flag stays set until a control write with bit 6 set clears it.
- R8: When idle, a CPU write to a pointer byte takes effect at once. During busy, such a write is held back: the pointer reads unchanged and the bus addresses are unaffected. On completion, the held bytes replace the matching bytes of the advanced pointer.
- R9: The vector bytes (offsets 4 to 6, low to high) are read-only. Control bits [1:0] read back the last written shift select.
- R10: The shift applied to a step is the select value at the trigger. A select written during busy affects only later steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Register window access strobe |
| cpu_we | input | 1 | Write enable for the access |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the addressed register (combinational) |
| mem_req | output | 1 | Bus read request |
| mem_addr | output | 24 | Byte address of the read |
| mem_gnt | input | 1 | Grant; data is valid in this cycle |
| mem_rdata | input | 8 | Read data byte |

## Verification
The bound checker watches the following on every cycle:
- the bus request holds its address until it is granted;
- a trigger from idle raises busy;
- a trigger during busy raises the overrun flag, and that flag stays set unless cleared;
- the vector moves only on the edge where busy falls after a grant.

Some results are numeric and can only be shown by the directed scenarios:
- the token value and its scaling for each shift select;
- the pointer carry across a bank;
- the overlay of pointer writes that were held back;
- the shift being taken at the trigger;
- the exact cycle in which busy clears.

// File: rtl/tna_pkg.sv
package tna_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } fetch_st_e;

   localparam int CTRL_OVR_BIT  = 6;
   localparam int CTRL_BUSY_BIT = 7;
endpackage

// File: rtl/tna_scaler.sv
module tna_scaler #(
   parameter int TOK_W = 16,
   parameter int OUT_W = 24,
   parameter int SEL_W = 2,
   parameter int STEP  = 2
) (
   input  logic [TOK_W-1:0] tok,
   input  logic [SEL_W-1:0] sel,
   output logic [OUT_W-1:0] addr
);
   localparam int N_OPT = 1 << SEL_W;
   localparam int MAX_SH = (N_OPT - 1) * STEP;

   if (TOK_W + MAX_SH > OUT_W) begin : g_bad_width
      $error("tna_scaler: widest scaled token exceeds OUT_W");
   end

   logic [OUT_W-1:0] wide;
   assign wide = {{(OUT_W-TOK_W){1'b0}}, tok};

   if (STEP == 0) begin : g_flat
      assign addr = wide;
   end else begin : g_mux
      logic [OUT_W-1:0] cand [N_OPT];
      for (genvar g = 0; g < N_OPT; g++) begin : g_opt
         localparam int SH = g * STEP;
         assign cand[g] = wide << SH;
      end
      assign addr = cand[sel];
   end
endmodule

// File: rtl/tna_fetch.sv
module tna_fetch
   import tna_pkg::*;
#(
   parameter int AW    = 24,
   parameter int TOK_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    ip,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   input  logic             mem_gnt,
   input  logic [7:0]       mem_rdata,
   output logic             busy,
   output logic             done,
   output logic [TOK_W-1:0] token
);
   localparam int BEATS = TOK_W / 8;
   localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

   fetch_st_e        st_q;
   logic [BW-1:0]    beat_q;
   logic [TOK_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
         acc_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_RUN;
                  beat_q <= '0;
               end
            end
            ST_RUN: begin
               if (mem_gnt) begin
                  acc_q[beat_q*8 +: 8] <= mem_rdata;
                  if (beat_q == LAST) st_q <= ST_IDLE;
                  else                beat_q <= beat_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req  = (st_q == ST_RUN);
   assign mem_addr = ip + AW'(beat_q);
   assign busy     = mem_req;
   assign done     = mem_req && mem_gnt && (beat_q == LAST);

   always_comb begin
      token = acc_q;
      token[(BEATS-1)*8 +: 8] = mem_rdata;
   end
endmodule

// File: rtl/tna_ptr.sv
module tna_ptr #(
   parameter int AW   = 24,
   parameter int STEP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [$clog2(AW/8 > 1 ? AW/8 : 2)-1:0] wr_idx,
   input  logic [7:0]      wr_data,
   input  logic            busy,
   input  logic            advance,
   output logic [AW-1:0]   ip
);
   localparam int NB = AW / 8;

   logic [AW-1:0] ip_q;
   logic [NB-1:0] pmask_q;
   logic [AW-1:0] pdata_q;
   logic [AW-1:0] merged;

   always_comb begin
      merged = ip_q + AW'(STEP);
      for (int b = 0; b < NB; b++) begin
         if (pmask_q[b]) merged[b*8 +: 8] = pdata_q[b*8 +: 8];
         if (wr_en && (int'(wr_idx) == b)) merged[b*8 +: 8] = wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip_q    <= '0;
         pmask_q <= '0;
         pdata_q <= '0;
      end else if (advance) begin
         ip_q    <= merged;
         pmask_q <= '0;
      end else if (wr_en && !busy) begin
         ip_q[wr_idx*8 +: 8] <= wr_data;
      end else if (wr_en) begin
         pmask_q[wr_idx]        <= 1'b1;
         pdata_q[wr_idx*8 +: 8] <= wr_data;
      end
   end

   assign ip = ip_q;
endmodule

// File: rtl/tok_next_accel.sv
module tok_next_accel
   import tna_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int TOK_W      = 16,
   parameter int SEL_W      = 2,
   parameter int SHIFT_STEP = 2,
   parameter int REG_AW     = $clog2(2*(ADDR_W/8) + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic [REG_AW-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic [7:0]        mem_rdata
);
   localparam int PTR_BYTES = ADDR_W / 8;
   localparam int IDXW      = $clog2(PTR_BYTES > 1 ? PTR_BYTES : 2);
   localparam int OFS_IP    = 1;
   localparam int OFS_VEC   = OFS_IP + PTR_BYTES;
   localparam int OFS_CTRL  = OFS_VEC + PTR_BYTES;
   localparam int BEATS     = TOK_W / 8;

   if (ADDR_W % 8 != 0 || TOK_W % 8 != 0) begin : g_bad_bytes
      $error("tok_next_accel: ADDR_W and TOK_W must be whole bytes");
   end
   if (TOK_W > ADDR_W) begin : g_bad_tok
      $error("tok_next_accel: token wider than address");
   end
   if (SEL_W > CTRL_OVR_BIT) begin : g_bad_sel
      $error("tok_next_accel: shift select overlaps status bits");
   end
   if ((1 << REG_AW) <= OFS_CTRL) begin : g_bad_raw
      $error("tok_next_accel: REG_AW too narrow for register window");
   end

   logic              wr, trig_wr, ctrl_wr, ip_wr;
   logic [IDXW-1:0]   ip_idx;
   logic              busy, done, start;
   logic [ADDR_W-1:0] ip;
   logic [TOK_W-1:0]  token;
   logic [ADDR_W-1:0] scaled;
   logic [SEL_W-1:0]  sel_q, sel_lat_q;
   logic              ovr_q;
   logic [ADDR_W-1:0] vec_q;

   assign wr      = cpu_sel && cpu_we;
   assign trig_wr = wr && (cpu_addr == REG_AW'(0));
   assign ctrl_wr = wr && (cpu_addr == REG_AW'(OFS_CTRL));
   assign start   = trig_wr && !busy;

   always_comb begin
      ip_wr  = 1'b0;
      ip_idx = '0;
      for (int b = 0; b < PTR_BYTES; b++) begin
         if (wr && cpu_addr == REG_AW'(OFS_IP + b)) begin
            ip_wr  = 1'b1;
            ip_idx = IDXW'(b);
         end
      end
   end

   tna_ptr #(.AW(ADDR_W), .STEP(BEATS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_en(ip_wr), .wr_idx(ip_idx),
      .wr_data(cpu_wdata), .busy(busy), .advance(done), .ip(ip)
   );

   tna_fetch #(.AW(ADDR_W), .TOK_W(TOK_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .ip(ip),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .token(token)
   );

   tna_scaler #(.TOK_W(TOK_W), .OUT_W(ADDR_W), .SEL_W(SEL_W), .STEP(SHIFT_STEP)) u_scale (
      .tok(token), .sel(sel_lat_q), .addr(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         sel_lat_q <= '0;
         ovr_q     <= 1'b0;
         vec_q     <= '0;
      end else begin
         if (ctrl_wr) sel_q <= cpu_wdata[SEL_W-1:0];
         if (start)   sel_lat_q <= sel_q;
         if (trig_wr && busy)                     ovr_q <= 1'b1;
         else if (ctrl_wr && cpu_wdata[CTRL_OVR_BIT]) ovr_q <= 1'b0;
         if (done)    vec_q <= scaled;
      end
   end

   always_comb begin
      cpu_rdata = '0;
      for (int b = 0; b < PTR_BYTES; b++) begin
         if (cpu_addr == REG_AW'(OFS_IP + b))  cpu_rdata = ip[b*8 +: 8];
         if (cpu_addr == REG_AW'(OFS_VEC + b)) cpu_rdata = vec_q[b*8 +: 8];
      end
      if (cpu_addr == REG_AW'(OFS_CTRL)) begin
         cpu_rdata[SEL_W-1:0]     = sel_q;
         cpu_rdata[CTRL_OVR_BIT]  = ovr_q;
         cpu_rdata[CTRL_BUSY_BIT] = busy;
      end
   end
endmodule

// File: rtl/tna_checker.sv
module tna_checker #(
   parameter int ADDR_W   = 24,
   parameter int REG_AW   = 3,
   parameter int OFS_CTRL = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_sel,
   input logic              cpu_we,
   input logic [REG_AW-1:0] cpu_addr,
   input logic [7:0]        cpu_wdata,
   input logic              busy,
   input logic              ovr,
   input logic [ADDR_W-1:0] vec,
   input logic              mem_req,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr
);
   logic trig, ctrl_clr;
   assign trig     = cpu_sel && cpu_we && (cpu_addr == REG_AW'(0));
   assign ctrl_clr = cpu_sel && cpu_we && (cpu_addr == REG_AW'(OFS_CTRL)) && cpu_wdata[6];

   // R3: an ungranted request keeps its address
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   // R2: trigger from idle starts the step
   assert_trig_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !busy) |=> busy);

   // R7: trigger while busy flags overrun
   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy) |=> ovr);

   // R7: overrun is sticky until an explicit clear
   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ctrl_clr) |=> ovr);

   // R6: vector moves only when busy falls
   assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(vec));

   // R6: completion follows a grant
   assert_done_on_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_gnt));
endmodule

bind tok_next_accel tna_checker #(
   .ADDR_W(ADDR_W), .REG_AW(REG_AW), .OFS_CTRL(OFS_CTRL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .busy(busy), .ovr(ovr_q),
   .vec(vec_q), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr)
);

// File: tb/sim_tok_next_accel.sv
module sim_tok_next_accel;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel = 1'b0, cpu_we = 1'b0;
   logic [2:0]  cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        mem_req, mem_gnt;
   logic [23:0] mem_addr;
   logic [7:0]  mem_rdata;

   int ntot = 0, nbad = 0;
   int gnt_delay = 0;
   int wcnt = 0;
   int gcnt = 0;
   logic [23:0] glog [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   tok_next_accel u0 (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] memfn(input logic [23:0] a);
      return a[23:16] ^ a[15:8] ^ {1'b0, a[7:1]} ^ (a[0] ? 8'h3C : 8'h00);
   endfunction

   assign mem_rdata = memfn(mem_addr);
   assign mem_gnt   = mem_req && (wcnt >= gnt_delay);

   always @(posedge clk) begin
      if (mem_req && !mem_gnt) wcnt <= wcnt + 1;
      else                     wcnt <= 0;
      if (mem_req && mem_gnt) begin
         glog[gcnt % 8] <= mem_addr;
         gcnt <= gcnt + 1;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      ntot++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      cpu_addr = a;
      #1;
      d = cpu_rdata;
   endtask

   task automatic set_ip(input logic [23:0] v);
      wr(3'd1, v[7:0]); wr(3'd2, v[15:8]); wr(3'd3, v[23:16]);
   endtask

   task automatic get_ip(output logic [23:0] v);
      logic [7:0] b0, b1, b2;
      rd(3'd1, b0); rd(3'd2, b1); rd(3'd3, b2);
      v = {b2, b1, b0};
   endtask

   task automatic get_vec(output logic [23:0] v);
      logic [7:0] b0, b1, b2;
      rd(3'd4, b0); rd(3'd5, b1); rd(3'd6, b2);
      v = {b2, b1, b0};
   endtask

   task automatic wait_idle();
      logic [7:0] c;
      for (int i = 0; i < 200; i++) begin
         rd(3'd7, c);
         if (!c[7]) break;
         @(negedge clk);
      end
   endtask

   function automatic logic [23:0] exp_vec(input logic [23:0] a, input int sel);
      logic [15:0] t;
      t = {memfn(a + 24'd1), memfn(a)};
      return ({8'h00, t} << (2 * sel));
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      for (int r = 0; r < 8; r++) begin
         rd(3'(r), d);
         check("R1 reset register", {24'h0, d}, 32'h0);
      end
      check("R1 no request after reset", {31'h0, mem_req}, 32'h0);
   endtask

   task automatic t_basic(input logic [23:0] a, input int sel, input int dly, input logic [7:0] tv);
      logic [23:0] v, p;
      logic [7:0]  c;
      int g0;
      gnt_delay = dly;
      set_ip(a);
      wr(3'd7, 8'(sel));
      g0 = gcnt;
      wr(3'd0, tv);
      rd(3'd7, c);
      check("R2 busy after trigger", {31'h0, c[7]}, 32'h1);
      wait_idle();
      get_vec(v);
      check("R5 scaled vector", {8'h0, v}, {8'h0, exp_vec(a, sel)});
      get_ip(p);
      check("R4 pointer advanced", {8'h0, p}, {8'h0, a + 24'd2});
      check("R3 two reads", gcnt - g0, 2);
      check("R3 low byte address", {8'h0, glog[g0 % 8]}, {8'h0, a});
      check("R3 high byte address", {8'h0, glog[(g0 + 1) % 8]}, {8'h0, a + 24'd1});
      rd(3'd7, c);
      check("R9 control select readback", {30'h0, c[1:0]}, sel);
   endtask

   task automatic t_timing();
      logic [7:0]  c;
      logic [23:0] v0, v;
      gnt_delay = 0;
      set_ip(24'h000340);
      wr(3'd7, 8'h00);
      get_vec(v0);
      wr(3'd0, 8'h00);
      rd(3'd7, c);
      check("R6 busy first cycle", {31'h0, c[7]}, 32'h1);
      get_vec(v);
      check("R6 vector held during fetch", {8'h0, v}, {8'h0, v0});
      @(negedge clk);
      rd(3'd7, c);
      check("R6 busy second cycle", {31'h0, c[7]}, 32'h1);
      @(negedge clk);
      rd(3'd7, c);
      check("R6 busy cleared", {31'h0, c[7]}, 32'h0);
      get_vec(v);
      check("R6 vector updated", {8'h0, v}, {8'h0, exp_vec(24'h000340, 0)});
   endtask

   task automatic t_overrun();
      logic [7:0]  c;
      logic [23:0] p;
      int g0;
      gnt_delay = 5;
      set_ip(24'h000200);
      wr(3'd7, 8'h01);
      g0 = gcnt;
      wr(3'd0, 8'h11);
      wr(3'd0, 8'h22);
      wait_idle();
      get_ip(p);
      check("R7 pointer moved once", {8'h0, p}, {8'h0, 24'h000202});
      check("R7 no extra reads", gcnt - g0, 2);
      rd(3'd7, c);
      check("R7 overrun set", {31'h0, c[6]}, 32'h1);
      wr(3'd7, 8'h01);
      rd(3'd7, c);
      check("R7 overrun sticky", {31'h0, c[6]}, 32'h1);
      wr(3'd7, 8'h41);
      rd(3'd7, c);
      check("R7 overrun cleared", {31'h0, c[6]}, 32'h0);
   endtask

   task automatic t_deferred();
      logic [23:0] p, v;
      int g0;
      gnt_delay = 6;
      set_ip(24'h0012F0);
      wr(3'd7, 8'h02);
      g0 = gcnt;
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h40);
      get_ip(p);
      check("R8 write held while busy", {8'h0, p}, {8'h0, 24'h0012F0});
      wait_idle();
      get_ip(p);
      check("R8 held byte overlays advanced pointer", {8'h0, p}, {8'h0, 24'h001240});
      check("R8 bus address unaffected", {8'h0, glog[(g0 + 1) % 8]}, {8'h0, 24'h0012F1});
      get_vec(v);
      check("R8 token from original pointer", {8'h0, v}, {8'h0, exp_vec(24'h0012F0, 2)});
   endtask

   task automatic t_shift_latch();
      logic [23:0] v;
      logic [7:0]  c;
      gnt_delay = 4;
      set_ip(24'h000A00);
      wr(3'd7, 8'h01);
      wr(3'd0, 8'h00);
      wr(3'd7, 8'h03);
      wait_idle();
      get_vec(v);
      check("R10 shift taken at trigger", {8'h0, v}, {8'h0, exp_vec(24'h000A00, 1)});
      rd(3'd7, c);
      check("R10 new select stored", {30'h0, c[1:0]}, 32'd3);
   endtask

   task automatic t_vec_readonly();
      logic [23:0] v0, v;
      get_vec(v0);
      wr(3'd4, 8'hAA); wr(3'd6, 8'h55);
      get_vec(v);
      check("R9 vector read-only", {8'h0, v}, {8'h0, v0});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      ntot++; nbad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic(24'h000100, 0, 0, 8'h00);
      t_basic(24'h000150, 1, 3, 8'hA5);
      t_basic(24'h00FF00, 3, 2, 8'hFF);   // R5 top token bits, 6-bit shift
      t_basic(24'h0003A2, 2, 1, 8'h5A);
      t_basic(24'h01FFFE, 1, 0, 8'h01);   // R4 carry into bank
      t_timing();
      t_overrun();
      t_deferred();
      t_shift_latch();
      t_vec_readonly();
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end
endmodule